// File: doc/BRIEF.md
# Radix-2 Fixed-Point Butterfly

This block performs one radix-2 decimation-in-time butterfly on 8-bit signed complex samples. It takes two complex operands, A and B, and a complex twiddle made of a cosine and a sine term. It rotates B by the twiddle and returns the pair A + W·B and A − W·B. Samples use four integer bits, the sign among them, and four fraction bits. Twiddle terms use six fraction bits, so −1.0 (−64) can be represented and the largest positive value is 63.

Each term of the rotation is an 8×8 signed product. Both products of a component are summed at full 16-bit width. Two guard bits stay free, so that sum cannot overflow. The sum is rounded half-up, shifted back to the sample format, added to A and subtracted from A, and then clipped to the 8-bit range. A sticky flag records whether any clip has happened.

The operands pass through two registered stages. Stage one forms the products and their sums. Stage two rounds, combines and saturates. Transfers use a valid/ready handshake on both sides. A four-state occupancy machine decides which stage loads. Its states are EMPTY (neither stage holds data), FRONT (only stage one), BACK (only stage two) and BOTH. Its transitions are:
- **accept**: EMPTY→FRONT.
- **advance**: FRONT→BACK, or FRONT→BOTH when a new operand arrives in the same cycle.
- **drain**: BACK→EMPTY.
- **refill**: BACK→FRONT, when a new operand arrives as the output leaves.
- **stack**: BACK→BOTH, when a new operand arrives while the output is held.
- **stream**: BOTH→BOTH while the output is consumed and a new operand arrives, or BOTH→BACK when no operand arrives.
- **stall**: BOTH→BOTH while the output is held.

Top module: `bfly_r2_unit`

## Requirements
- R1: The rotated term is re = cos·Br − sin·Bi and im = cos·Bi + sin·Br. The products are signed 8×8 with 16-bit results. Twiddle terms are signed with six fraction bits, in the range [−64, 63]. Samples are signed with four fraction bits.
- R2: Each 16-bit rotated sum is rounded half-up: add 32, then shift right arithmetically by 6. Thus 32 gives 1 and −32 gives 0.
- R3: sum_re/sum_im equal A plus the rounded rotated term, and dif_re/dif_im equal A minus it, whenever no clip occurs.
- R4: Each of the four results saturates to [−128, 127].
- R5: ovf_sticky becomes 1 when a result that clipped in any of its four components enters the output register. It stays 1 until reset.
- R6: An operand accepted at clock edge k makes out_valid high after edge k+1 when the pipeline was empty. out_valid is still low between edges k and k+1.
- R7: While out_valid is high and out_ready is low, out_valid stays high and all four results stay unchanged.
- R8: in_ready is high whenever out_valid is low or out_ready is high.
- R9: While rst_n is low, out_valid and ovf_sticky are 0. After reset, in_ready is 1.
- R10: Results leave in the order their operands were accepted, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken |
| a_re | input | DW | Real part of A (signed, 4 fraction bits) |
| a_im | input | DW | Imaginary part of A |
| b_re | input | DW | Real part of B |
| b_im | input | DW | Imaginary part of B |
| w_cos | input | TW | Twiddle cosine term (signed, 6 fraction bits) |
| w_sin | input | TW | Twiddle sine term |
| out_valid | output | 1 | Results present |
| out_ready | input | 1 | Downstream takes the results |
| sum_re | output | DW | Real part of A + W·B, saturated |
| sum_im | output | DW | Imaginary part of A + W·B, saturated |
| dif_re | output | DW | Real part of A − W·B, saturated |
| dif_im | output | DW | Imaginary part of A − W·B, saturated |
| ovf_sticky | output | 1 | Set once any result has clipped |

## Verification
An operand set taken at edge k sits in stage one after edge k and reaches the outputs after edge k+1. The sticky flag changes on that same edge. The bench drives inputs on the falling edge and samples a quarter period before the next rising edge. At each sample point it records a transfer if the handshake is live, so every arithmetic result is compared in the cycle its out_valid/out_ready pair is seen. That comparison is made against a queue of expected values filled when the operands were accepted. One directed probe checks the two-edge delay exactly. It reads out_valid low before edge k+1 and high before edge k+2.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    // Which pipeline stages currently hold data.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_FRONT = 2'd1,
        OCC_BACK  = 2'd2,
        OCC_BOTH  = 2'd3
    } occ_t;
endpackage

// File: rtl/bfly_pipe_ctrl.sv
module bfly_pipe_ctrl
    import bfly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic ld_front,
    output logic ld_back
);
    occ_t st, st_nx;
    logic front_full, back_full, back_free;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OCC_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        front_full = (st == OCC_FRONT) || (st == OCC_BOTH);
        back_full  = (st == OCC_BACK)  || (st == OCC_BOTH);
        back_free  = !back_full || out_ready;
        in_ready   = !front_full || back_free;
        ld_front   = in_valid && in_ready;
        ld_back    = front_full && back_free;
        out_valid  = back_full;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            OCC_EMPTY: st_nx = ld_front ? OCC_FRONT : OCC_EMPTY;
            OCC_FRONT: st_nx = ld_front ? OCC_BOTH  : OCC_BACK;
            OCC_BACK: begin
                if (out_ready) st_nx = ld_front ? OCC_FRONT : OCC_EMPTY;
                else           st_nx = ld_front ? OCC_BOTH  : OCC_BACK;
            end
            OCC_BOTH: begin
                if (out_ready) st_nx = ld_front ? OCC_BOTH : OCC_BACK;
                else           st_nx = OCC_BOTH;
            end
            default:   st_nx = OCC_EMPTY;
        endcase
    end
endmodule

// File: rtl/bfly_rotate.sv
module bfly_rotate #(
    parameter int DW = 8,
    parameter int TW = 8,
    localparam int PW = DW + TW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_cos,
    input  logic signed [TW-1:0] w_sin,
    output logic [1:0][PW-1:0]   rot_q,
    output logic [1:0][DW-1:0]   a_q
);
    logic signed [PW-1:0] p_cr, p_ci, p_sr, p_si;
    logic signed [PW-1:0] s_re, s_im;

    // Q6 twiddles leave two sign bits per product, so each pair sums in PW bits.
    always_comb begin
        p_cr = w_cos * b_re;
        p_ci = w_cos * b_im;
        p_sr = w_sin * b_re;
        p_si = w_sin * b_im;
        s_re = p_cr - p_si;
        s_im = p_ci + p_sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_q <= '0;
            a_q   <= '0;
        end else if (ld) begin
            rot_q <= {s_im, s_re};
            a_q   <= {a_im, a_re};
        end
    end
endmodule

// File: rtl/bfly_combine.sv
module bfly_combine #(
    parameter int DW    = 8,
    parameter int TW    = 8,
    parameter int TFRAC = 6,
    localparam int PW = DW + TW,
    localparam int RW = PW + 1,
    localparam int XW = PW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [1:0][PW-1:0] rot,
    input  logic [1:0][DW-1:0] a_in,
    output logic [1:0][DW-1:0] sum_q,
    output logic [1:0][DW-1:0] dif_q,
    output logic               ovf_q
);
    localparam logic signed [RW-1:0] HALF = RW'(1) <<< (TFRAC - 1);
    localparam logic signed [XW-1:0] SMAX = XW'((1 << (DW - 1)) - 1);
    localparam logic signed [XW-1:0] SMIN = -XW'(1 << (DW - 1));

    logic [1:0][DW-1:0] sum_nx, dif_nx;
    logic [1:0]         clip;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic signed [RW-1:0] ext, ext_h, rnd;
        logic signed [XW-1:0] a_x, r_x, s_w, d_w;
        logic                 s_hi, s_lo, d_hi, d_lo;

        assign ext   = {rot[l][PW-1], rot[l]};
        assign ext_h = ext + HALF;
        assign rnd   = ext_h >>> TFRAC;
        assign a_x   = {{(XW-DW){a_in[l][DW-1]}}, a_in[l]};
        assign r_x   = {{(XW-RW){rnd[RW-1]}}, rnd};
        assign s_w   = a_x + r_x;
        assign d_w   = a_x - r_x;
        assign s_hi  = s_w > SMAX;
        assign s_lo  = s_w < SMIN;
        assign d_hi  = d_w > SMAX;
        assign d_lo  = d_w < SMIN;
        assign sum_nx[l] = s_hi ? SMAX[DW-1:0] : (s_lo ? SMIN[DW-1:0] : s_w[DW-1:0]);
        assign dif_nx[l] = d_hi ? SMAX[DW-1:0] : (d_lo ? SMIN[DW-1:0] : d_w[DW-1:0]);
        assign clip[l]   = s_hi | s_lo | d_hi | d_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            dif_q <= '0;
            ovf_q <= 1'b0;
        end else if (ld) begin
            sum_q <= sum_nx;
            dif_q <= dif_nx;
            if (|clip) ovf_q <= 1'b1;
        end
    end
endmodule

// File: rtl/bfly_r2_unit.sv
module bfly_r2_unit #(
    parameter int DW    = 8,
    parameter int TW    = 8,
    parameter int TFRAC = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_cos,
    input  logic signed [TW-1:0] w_sin,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] sum_re,
    output logic signed [DW-1:0] sum_im,
    output logic signed [DW-1:0] dif_re,
    output logic signed [DW-1:0] dif_im,
    output logic                 ovf_sticky
);
    localparam int PW = DW + TW;

    logic               ld_front, ld_back;
    logic [1:0][PW-1:0] rot_q;
    logic [1:0][DW-1:0] a_q, sum_q, dif_q;

    bfly_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .ld_front  (ld_front),
        .ld_back   (ld_back)
    );

    bfly_rotate #(.DW(DW), .TW(TW)) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_front),
        .a_re  (a_re),
        .a_im  (a_im),
        .b_re  (b_re),
        .b_im  (b_im),
        .w_cos (w_cos),
        .w_sin (w_sin),
        .rot_q (rot_q),
        .a_q   (a_q)
    );

    bfly_combine #(.DW(DW), .TW(TW), .TFRAC(TFRAC)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_back),
        .rot   (rot_q),
        .a_in  (a_q),
        .sum_q (sum_q),
        .dif_q (dif_q),
        .ovf_q (ovf_sticky)
    );

    assign sum_re = sum_q[0];
    assign sum_im = sum_q[1];
    assign dif_re = dif_q[0];
    assign dif_im = dif_q[1];
endmodule

// File: rtl/bfly_r2_chk.sv
module bfly_r2_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] sum_re,
    input logic [DW-1:0] sum_im,
    input logic [DW-1:0] dif_re,
    input logic [DW-1:0] dif_im,
    input logic          ovf_sticky
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({sum_re, sum_im, dif_re, dif_im})));

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sticky) |-> out_valid);

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !out_valid) |-> ##2 out_valid);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r9: assert (!out_valid && !ovf_sticky);
        end
    end
endmodule

bind bfly_r2_unit bfly_r2_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .sum_re     (sum_re),
    .sum_im     (sum_im),
    .dif_re     (dif_re),
    .dif_im     (dif_im),
    .ovf_sticky (ovf_sticky)
);

// File: tb/bfly_r2_unit_tb.sv
module bfly_r2_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic signed [7:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [7:0] w_cos = '0, w_sin = '0;
    logic in_ready, out_valid, ovf_sticky;
    logic signed [7:0] sum_re, sum_im, dif_re, dif_im;

    always #10 clk = ~clk;

    bfly_r2_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_cos(w_cos), .w_sin(w_sin), .out_valid(out_valid), .out_ready(out_ready),
        .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im),
        .ovf_sticky(ovf_sticky)
    );

    int checks = 0;
    int errs = 0;
    logic [32:0] expq [0:16383];
    string       tagq [0:16383];
    int wr = 0;
    int rd = 0;
    int cyc = 0;
    bit bp = 0;
    bit exp_sticky = 0;
    bit hold_pend = 0;
    logic [31:0] hold_val;
    bit last_acc = 0;
    string cur_tag = "R3";
    int cur[6];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] model(int ar, int ai, int br, int bi, int c, int s);
        int re, im, rr, ri;
        int v[4];
        bit clip;
        re = c * br - s * bi;
        im = c * bi + s * br;
        rr = (re + 32) >>> 6;
        ri = (im + 32) >>> 6;
        v[0] = ar + rr; v[1] = ai + ri; v[2] = ar - rr; v[3] = ai - ri;
        clip = 0;
        for (int k = 0; k < 4; k++) begin
            if (v[k] > 127)       begin v[k] = 127;  clip = 1; end
            else if (v[k] < -128) begin v[k] = -128; clip = 1; end
        end
        return {clip, 8'(v[0]), 8'(v[1]), 8'(v[2]), 8'(v[3])};
    endfunction

    // Scoreboard work at a sample point a quarter period before the rising edge.
    task automatic sample();
        logic [31:0] got;
        bit clip;
        got = {sum_re, sum_im, dif_re, dif_im};
        if (hold_pend)
            chk(out_valid && got == hold_val, "R7", {31'd0, out_valid, got}, {32'd1, hold_val});
        hold_pend = out_valid && !out_ready;
        hold_val  = got;
        if (!out_valid || out_ready)
            chk(in_ready == 1'b1, "R8", 64'(in_ready), 64'd1);
        if (out_valid && out_ready) begin
            if (rd == wr) begin
                chk(0, "R10", 64'(got), 64'd0);
            end else begin
                clip = expq[rd][32];
                chk(got == expq[rd][31:0], clip ? "R4" : tagq[rd], 64'(got), 64'(expq[rd][31:0]));
                exp_sticky = exp_sticky | clip;
                chk(ovf_sticky == exp_sticky, "R5", 64'(ovf_sticky), 64'(exp_sticky));
                rd++;
            end
        end
        last_acc = in_valid && in_ready;
        if (last_acc) begin
            expq[wr] = model(cur[0], cur[1], cur[2], cur[3], cur[4], cur[5]);
            tagq[wr] = cur_tag;
            wr++;
        end
    endtask

    task automatic tick();
        #5;
        sample();
        @(negedge clk);
        cyc++;
        out_ready = !bp || ((cyc % 3) != 0);
    endtask

    task automatic offer(input int ar, input int ai, input int br, input int bi,
                         input int c, input int s, input string t);
        if (bp && (cyc % 5) == 0) tick();
        cur[0] = ar; cur[1] = ai; cur[2] = br; cur[3] = bi; cur[4] = c; cur[5] = s;
        a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br); b_im = 8'(bi);
        w_cos = 8'(c); w_sin = 8'(s);
        cur_tag = t;
        in_valid = 1'b1;
        forever begin
            tick();
            if (last_acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        bp = 0;
        out_ready = 1'b1;
        for (int i = 0; i < 20 && rd != wr; i++) tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #35;
        // R9: values held in reset
        chk(out_valid == 1'b0 && ovf_sticky == 1'b0, "R9", {out_valid, ovf_sticky}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        chk(out_valid == 1'b0 && in_ready == 1'b1 && ovf_sticky == 1'b0, "R9",
            {out_valid, in_ready, ovf_sticky}, 3'b010);
        @(negedge clk);

        // R1: pure sine rotation; R2: half values round upward
        offer(0, 0, 16, -32, 0, 63, "R1");
        offer(5, -3, 20, 7, -64, 0, "R1");
        offer(0, 0, 1, 0, 32, 0, "R2");
        offer(0, 0, -1, 0, 32, 0, "R2");
        offer(10, 10, 3, -5, 32, -32, "R2");
        drain();

        // R6: exact two-edge delay from an empty pipeline
        offer(1, 2, 3, 4, 40, 20, "R6");
        #5;
        chk(out_valid == 1'b0, "R6", 64'(out_valid), 64'd0);
        @(negedge clk);
        #5;
        chk(out_valid == 1'b1, "R6", 64'(out_valid), 64'd1);
        sample();
        @(negedge clk);
        drain();

        // R4 corners: extreme twiddles and samples
        offer(127, -128, 127, 127, 63, 63, "R4");
        offer(-128, 127, -128, -128, -64, -64, "R4");
        offer(0, 0, -128, 0, -64, 0, "R4");
        drain();

        // Near-exhaustive sweep, second half under output backpressure
        for (int c = -64; c <= 63; c += 7) begin
            bp = (c > 0);
            for (int s = -64; s <= 63; s += 7) begin
                for (int br = -128; br <= 127; br += 51) begin
                    for (int bi = -128; bi <= 127; bi += 51) begin
                        int ar, ai;
                        ar = ((wr * 37) % 256) - 128;
                        ai = ((wr * 91) % 256) - 128;
                        offer(ar, ai, br, bi, c, s, "R3");
                    end
                end
            end
        end
        drain();
        for (int i = 0; i < 4; i++) tick();

        // R10: every accepted operand produced exactly one result
        chk(rd == wr, "R10", 64'(rd), 64'(wr));
        chk(ovf_sticky == 1'b1, "R5", 64'(ovf_sticky), 64'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule